// File: doc/BRIEF.md
# E1 Transmit Framer with CRC-4

This block sits on the transmit side of a 2.048 Mb/s E1 port. A serial payload stream arrives one bit per clock. The stream is organised as 256-bit frames of 32 eight-bit timeslots, and sixteen frames make a multiframe. The block replaces the overhead positions of that stream with framing content and sends the result out one clock later. In timeslot 0 it writes the frame alignment word on even frames and the fixed one bit on odd frames. When CRC-4 is on, it fills the first bit of timeslot 0 with the CRC-4 multiframe pattern, the checksum bits and the E-bits.

The block computes the checksum itself. It runs over each eight-frame half of the multiframe, with the checksum positions counted as zero. The result goes out in the checksum positions of the following half. Timeslot 16 either gets the signalling multiframe alignment nibble and the four spare/alarm bits in frame 0, or it passes through unchanged in common-channel mode.

A rising edge on the multiframe sync input sets the position of the multiframe. A frame strobe moves the bit position back to the start of a frame. Between the two, the block keeps its own position and wraps it.

Top module: `e1tx_framer`

## Requirements
- R1: While `rst` is high at a clock edge, `ser_out` is 0 after that edge, and the position is frame 0, bit 1 of timeslot 0.
- R2: On even frames, bits 2 to 8 of timeslot 0 leave as 0,0,1,1,0,1,1 in that order, whatever `ser_in` holds.
- R3: On odd frames, bit 2 of timeslot 0 leaves as 1, and bits 3 to 8 come from `ser_in`.
- R4: With `crc_en` low, bit 1 of timeslot 0 comes from `ser_in` on every frame.
- R5: With `crc_en` high, bit 1 of timeslot 0 on frames 1, 3, 5, 7, 9 and 11 carries 0,0,1,0,1,1 in that frame order.
- R6: With `crc_en` high, bit 1 of timeslot 0 carries `e_bits[0]` on frame 13 and `e_bits[1]` on frame 15.
- R7: With `crc_en` high, bit 1 of timeslot 0 on frames 0,2,4,6 (and 8,10,12,14) carries the checksum of the previous eight-frame half, most significant bit first. The checksum is the remainder of the data times x^4, divided by x^4+x+1, over all 2048 output bits of that half, with the checksum positions taken as 0. The first half after reset sends 0000.
- R8: In a cycle where `msync` is high and was low in the cycle before, that cycle's bit is bit 1 of timeslot 0 of frame 0. Holding `msync` high afterwards has no further effect.
- R9: When `fsync` is high and R8 does not apply, that cycle's bit is bit 1 of timeslot 0. The frame number advances by one, unless the block was already at bit 1 of timeslot 0. Without either strobe, the bit position wraps after bit 256 and the frame number after frame 15.
- R10: With `cas_en` high and `ccs_en` low, timeslot 16 of frame 0 leaves as 0,0,0,0 followed by `cas_spare[3]` down to `cas_spare[0]`. Timeslot 16 of the other frames comes from `ser_in`.
- R11: With `ccs_en` high, all eight bits of timeslot 16 in every frame come from `ser_in`, whatever `cas_en` holds.
- R12: Each `ser_out` bit leaves exactly one clock after the `ser_in` bit whose position it takes.
- R13: Timeslots 1 to 15 and 17 to 31 pass from `ser_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial payload bit |
| fsync | input | 1 | Frame start strobe (bit 1 of timeslot 0) |
| msync | input | 1 | Multiframe sync; a rising edge marks frame 0 |
| crc_en | input | 1 | Enables CRC-4 content in the first bit of timeslot 0 |
| cas_en | input | 1 | Enables signalling alignment insertion in timeslot 16 |
| ccs_en | input | 1 | Common-channel mode: timeslot 16 passes through |
| e_bits | input | 2 | E-bit values for frame 13 (bit 0) and frame 15 (bit 1) |
| cas_spare | input | 4 | Spare and alarm bits for the lower nibble of timeslot 16, frame 0 |
| ser_out | output | 1 | Framed serial output |

## Verification
The hardest case to reach is a checksum bit. Its value depends on all 2048 bits of the previous half-multiframe. It also depends on where the block believes the half started, and a frame strobe in mid-frame or a second multiframe edge can move that point. The stimulus runs more than two full multiframes of pseudo-random payload per configuration. Some runs add a late frame strobe at an odd offset, a second multiframe edge, or a multiframe input that is held high. The bench follows the position and checksum from the requirements and compares every output bit, grouped by the requirement that governs its position.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;

    localparam int SLOT_BITS  = 8;
    localparam int SLOTS      = 32;
    localparam int MF_FRAMES  = 16;
    localparam int SIG_SLOT   = 16;
    localparam int MFA_LEN    = 6;

    localparam int FRAME_BITS = SLOT_BITS * SLOTS;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int FRM_W      = $clog2(MF_FRAMES);
    localparam int SLOT_W     = $clog2(SLOT_BITS);
    localparam int SMF_FRAMES = MF_FRAMES / 2;

    localparam logic [6:0]         FAS_WORD = 7'b0011011;
    localparam logic [MFA_LEN-1:0] MFA_WORD = 6'b001011;

    typedef struct packed {
        logic [FRM_W-1:0] frame;
        logic [BIT_W-1:0] bitpos;
    } pos_t;

    typedef enum logic [2:0] {
        SRC_PAYLOAD,
        SRC_FAS,
        SRC_ONE,
        SRC_CBIT,
        SRC_MFA,
        SRC_EBIT,
        SRC_ZERO,
        SRC_SPARE
    } src_e;

    // one serial step of the x^4+x+1 remainder (data pre-multiplied by x^4)
    function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
        logic fb;
        fb = b ^ c[3];
        return {c[2], c[1], c[0] ^ fb, fb};
    endfunction

endpackage

// File: rtl/e1tx_timing.sv
module e1tx_timing
    import e1tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fsync,
    input  logic msync,
    output pos_t pos
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    logic [BIT_W-1:0] bit_q;
    logic [FRM_W-1:0] frm_q;
    logic             ms_q;
    logic             ms_rise;

    assign ms_rise = msync & ~ms_q;

    always_comb begin
        pos.frame  = frm_q;
        pos.bitpos = bit_q;
        if (ms_rise) begin
            pos = '0;
        end else if (fsync) begin
            pos.bitpos = '0;
            pos.frame  = (bit_q == '0) ? frm_q : frm_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= '0;
            frm_q <= '0;
            ms_q  <= 1'b0;
        end else begin
            ms_q <= msync;
            if (pos.bitpos == LAST_BIT) begin
                bit_q <= '0;
                frm_q <= pos.frame + 1'b1;
            end else begin
                bit_q <= pos.bitpos + 1'b1;
                frm_q <= pos.frame;
            end
        end
    end
endmodule

// File: rtl/e1tx_crc.sv
module e1tx_crc
    import e1tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pos_t       pos,
    input  logic       crc_bit,
    output logic [3:0] c_word
);
    localparam logic [FRM_W-1:0] SMF_MASK = FRM_W'(SMF_FRAMES - 1);

    logic [3:0] acc_q;
    logic [3:0] hold_q;
    logic       smf_start;

    assign smf_start = (pos.bitpos == '0) && ((pos.frame & SMF_MASK) == '0);
    // at the first bit of a half the finished remainder is still in acc_q
    assign c_word    = smf_start ? acc_q : hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            hold_q <= '0;
        end else if (smf_start) begin
            hold_q <= acc_q;
            acc_q  <= crc4_step(4'b0000, crc_bit);
        end else begin
            acc_q  <= crc4_step(acc_q, crc_bit);
        end
    end
endmodule

// File: rtl/e1tx_mux.sv
module e1tx_mux
    import e1tx_pkg::*;
(
    input  pos_t       pos,
    input  logic       ser_in,
    input  logic       crc_en,
    input  logic       cas_en,
    input  logic       ccs_en,
    input  logic [1:0] e_bits,
    input  logic [3:0] cas_spare,
    input  logic [3:0] c_word,
    output logic       tx_bit,
    output logic       crc_bit
);
    localparam int                          SLOT_IDX_W = BIT_W - SLOT_W;
    localparam logic [SLOT_IDX_W-1:0]       SIG_IDX    = SLOT_IDX_W'(SIG_SLOT);
    localparam logic [FRM_W-2:0]            MFA_PAIRS  = (FRM_W-1)'(MFA_LEN);
    localparam logic [SLOT_W-1:0]           TOP_K      = SLOT_W'(SLOT_BITS - 1);
    localparam logic [SLOT_W-1:0]           HALF_K     = SLOT_W'(SLOT_BITS / 2);

    logic [SLOT_W-1:0]     k;
    logic [SLOT_IDX_W-1:0] slot;
    logic [FRM_W-2:0]      fpair;
    logic                  odd;
    src_e                  sel;

    assign k     = pos.bitpos[SLOT_W-1:0];
    assign slot  = pos.bitpos[BIT_W-1:SLOT_W];
    assign fpair = pos.frame[FRM_W-1:1];
    assign odd   = pos.frame[0];

    always_comb begin
        sel = SRC_PAYLOAD;
        if (slot == '0) begin
            if (k == '0) begin
                if (crc_en) begin
                    if (!odd)                   sel = SRC_CBIT;
                    else if (fpair < MFA_PAIRS) sel = SRC_MFA;
                    else                        sel = SRC_EBIT;
                end
            end else if (!odd) begin
                sel = SRC_FAS;
            end else if (k == SLOT_W'(1)) begin
                sel = SRC_ONE;
            end
        end else if (slot == SIG_IDX && cas_en && !ccs_en && pos.frame == '0) begin
            sel = (k < HALF_K) ? SRC_ZERO : SRC_SPARE;
        end
    end

    always_comb begin
        case (sel)
            SRC_FAS:   tx_bit = FAS_WORD[TOP_K - k];
            SRC_ONE:   tx_bit = 1'b1;
            SRC_CBIT:  tx_bit = c_word[2'd3 - pos.frame[2:1]];
            SRC_MFA:   tx_bit = MFA_WORD[3'(MFA_LEN - 1) - fpair];
            SRC_EBIT:  tx_bit = e_bits[pos.frame[1]];
            SRC_ZERO:  tx_bit = 1'b0;
            SRC_SPARE: tx_bit = cas_spare[~k[1:0]];
            default:   tx_bit = ser_in;
        endcase
        crc_bit = (sel == SRC_CBIT) ? 1'b0 : tx_bit;
    end
endmodule

// File: rtl/e1tx_framer.sv
module e1tx_framer
    import e1tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_in,
    input  logic       fsync,
    input  logic       msync,
    input  logic       crc_en,
    input  logic       cas_en,
    input  logic       ccs_en,
    input  logic [1:0] e_bits,
    input  logic [3:0] cas_spare,
    output logic       ser_out
);
    pos_t       cur_pos;
    logic [3:0] c_word;
    logic       tx_bit;
    logic       crc_bit;

    e1tx_timing u_tim (
        .clk   (clk),
        .rst   (rst),
        .fsync (fsync),
        .msync (msync),
        .pos   (cur_pos)
    );

    e1tx_crc u_crc (
        .clk     (clk),
        .rst     (rst),
        .pos     (cur_pos),
        .crc_bit (crc_bit),
        .c_word  (c_word)
    );

    e1tx_mux u_mux (
        .pos       (cur_pos),
        .ser_in    (ser_in),
        .crc_en    (crc_en),
        .cas_en    (cas_en),
        .ccs_en    (ccs_en),
        .e_bits    (e_bits),
        .cas_spare (cas_spare),
        .c_word    (c_word),
        .tx_bit    (tx_bit),
        .crc_bit   (crc_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) ser_out <= 1'b0;
        else     ser_out <= tx_bit;
    end
endmodule

// File: rtl/e1tx_framer_chk.sv
module e1tx_framer_chk
    import e1tx_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic ser_in,
    input logic msync,
    input logic crc_en,
    input logic ccs_en,
    input logic ser_out,
    input pos_t pos
);
    pos_t pp_q;
    logic in_q, crc_q, ccs_q, ms_q, vld_q;

    always_ff @(posedge clk) begin
        pp_q  <= pos;
        in_q  <= ser_in;
        crc_q <= crc_en;
        ccs_q <= ccs_en;
        ms_q  <= rst ? 1'b0 : msync;
        vld_q <= ~rst;
    end

    // R2: alignment word on even frames
    p_fas_r2: assert property (@(posedge clk) disable iff (rst || !vld_q)
        (!pp_q.frame[0] && pp_q.bitpos >= BIT_W'(1) && pp_q.bitpos <= BIT_W'(7))
        |-> ser_out == FAS_WORD[3'd7 - pp_q.bitpos[2:0]])
        else $error("R2 alignment word bit wrong");

    // R3: bit 2 of odd frames is one
    p_nfas_r3: assert property (@(posedge clk) disable iff (rst || !vld_q)
        (pp_q.frame[0] && pp_q.bitpos == BIT_W'(1)) |-> ser_out)
        else $error("R3 odd-frame bit 2 not one");

    // R5: multiframe pattern on odd frames 1..11
    p_mfa_r5: assert property (@(posedge clk) disable iff (rst || !vld_q)
        (crc_q && pp_q.frame[0] && pp_q.frame < FRM_W'(12) && pp_q.bitpos == '0)
        |-> ser_out == MFA_WORD[3'd5 - pp_q.frame[3:1]])
        else $error("R5 multiframe pattern bit wrong");

    // R8: a rising multiframe edge lands on frame 0, bit 1
    p_mrise_r8: assert property (@(posedge clk) disable iff (rst || !vld_q)
        (msync && !ms_q) |-> pos == '0)
        else $error("R8 multiframe edge misplaced");

    // R11: common-channel timeslot 16 passes through
    p_ccs_r11: assert property (@(posedge clk) disable iff (rst || !vld_q)
        (ccs_q && pp_q.bitpos[7:3] == 5'd16) |-> ser_out == in_q)
        else $error("R11 timeslot 16 not passed");

    // R13 and R12: payload timeslots pass with one clock of delay
    p_pass_r13: assert property (@(posedge clk) disable iff (rst || !vld_q)
        (pp_q.bitpos[7:3] != 5'd0 && pp_q.bitpos[7:3] != 5'd16) |-> ser_out == in_q)
        else $error("R13 payload bit altered");
endmodule

bind e1tx_framer e1tx_framer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ser_in  (ser_in),
    .msync   (msync),
    .crc_en  (crc_en),
    .ccs_en  (ccs_en),
    .ser_out (ser_out),
    .pos     (cur_pos)
);

// File: tb/e1tx_framer_bench.sv
module e1tx_framer_bench;
    localparam int PERIOD = 10;
    localparam int RUN    = 8200;
    localparam int NCAT   = 9;

    typedef struct packed {
        logic        crc;
        logic        cas;
        logic        ccs;
        logic        hold_ms;
        logic [1:0]  eb;
        logic [3:0]  spare;
        logic [15:0] fs_at;
        logic [15:0] ms2_at;
        logic [15:0] seed;
    } scen_t;

    localparam scen_t TBL [5] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'b0000, 16'd0,    16'd0,    16'hACE1},
        '{1'b1, 1'b1, 1'b0, 1'b0, 2'b10, 4'b1011, 16'd0,    16'd0,    16'h1D0F},
        '{1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 4'b1111, 16'd0,    16'd0,    16'h7777},
        '{1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 4'b0000, 16'd1000, 16'd0,    16'h0BAD},
        '{1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 4'b0110, 16'd0,    16'd5003, 16'hBEEF}
    };

    localparam string CAT_NAME [NCAT] = '{
        "R2 alignment word", "R3 odd-frame bits", "R4 international pass",
        "R5 multiframe pattern", "R6 E bits", "R7 checksum bits",
        "R10 timeslot 16 CAS", "R11 timeslot 16 CCS", "R13 payload"
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0, fsync = 1'b0, msync = 1'b0;
    logic crc_en = 1'b0, cas_en = 1'b0, ccs_en = 1'b0;
    logic [1:0] e_bits = '0;
    logic [3:0] cas_spare = '0;
    logic ser_out;

    int tests = 0;
    int fails = 0;

    // bench model state
    int         m_bit, m_frm;
    logic       m_ms_prev;
    logic [3:0] m_crc, m_hold;
    int         mis [NCAT];
    int         seen [NCAT];
    logic       fa [NCAT];
    logic       fe [NCAT];

    always #(PERIOD/2) clk = ~clk;

    e1tx_framer u_e1tx_framer (
        .clk(clk), .rst(rst), .ser_in(ser_in), .fsync(fsync), .msync(msync),
        .crc_en(crc_en), .cas_en(cas_en), .ccs_en(ccs_en),
        .e_bits(e_bits), .cas_spare(cas_spare), .ser_out(ser_out)
    );

    function automatic logic [3:0] step4(input logic [3:0] c, input logic b);
        logic f;
        f = b ^ c[3];
        return {c[2], c[1], c[0] ^ f, f};
    endfunction

    function automatic logic exp_bit(input int eb, input int ef, input logic din,
                                     input scen_t s, input logic [3:0] hold,
                                     output int cat);
        logic [6:0] fas = 7'b0011011;
        logic [5:0] mfa = 6'b001011;
        if (eb == 0) begin
            if (!s.crc)          begin cat = 2; return din; end
            if (ef % 2 == 0)     begin cat = 5; return hold[3 - (ef % 8) / 2]; end
            if (ef <= 11)        begin cat = 3; return mfa[5 - (ef - 1) / 2]; end
            cat = 4;
            return (ef == 13) ? s.eb[0] : s.eb[1];
        end
        if (eb < 8) begin
            if (ef % 2 == 0) begin cat = 0; return fas[7 - eb]; end
            cat = 1;
            return (eb == 1) ? 1'b1 : din;
        end
        if (eb >= 128 && eb < 136) begin
            if (s.ccs) begin cat = 7; return din; end
            cat = 6;
            if (s.cas && ef == 0) return (eb < 132) ? 1'b0 : s.spare[135 - eb];
            return din;
        end
        cat = 8;
        return din;
    endfunction

    task automatic check(input string req, input logic ok, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; fsync = 1'b0; msync = 1'b0; ser_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: output cleared by reset
        check("R1 reset output", ser_out == 1'b0, ser_out, 0);
        m_bit = 0; m_frm = 0; m_ms_prev = 1'b0; m_crc = '0; m_hold = '0;
    endtask

    task automatic run_scen(input int idx);
        scen_t s;
        logic [15:0] lf;
        int total;
        s = TBL[idx];
        crc_en = s.crc; cas_en = s.cas; ccs_en = s.ccs;
        e_bits = s.eb; cas_spare = s.spare;
        do_reset();
        for (int i = 0; i < NCAT; i++) begin mis[i] = 0; seen[i] = 0; end
        lf = s.seed;
        total = 0;
        for (int c = 0; c < RUN; c++) begin
            int eb, ef, cat;
            logic e, rise;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            ser_in = lf[0];
            msync  = (c == 0) || s.hold_ms || (s.ms2_at != 0 && c == int'(s.ms2_at));
            fsync  = (s.fs_at != 0 && c == int'(s.fs_at));
            rise = msync && !m_ms_prev;
            m_ms_prev = msync;
            if (rise) begin eb = 0; ef = 0; end
            else if (fsync) begin ef = (m_bit == 0) ? m_frm : (m_frm + 1) % 16; eb = 0; end
            else begin eb = m_bit; ef = m_frm; end
            if (eb == 0 && ef % 8 == 0) begin m_hold = m_crc; m_crc = '0; end
            e = exp_bit(eb, ef, ser_in, s, m_hold, cat);
            m_crc = step4(m_crc, (s.crc && ef % 2 == 0 && eb == 0) ? 1'b0 : e);
            m_bit = (eb + 1) % 256;
            m_frm = (eb == 255) ? (ef + 1) % 16 : ef;
            // R12: the bit appears one clock later
            @(negedge clk);
            seen[cat]++;
            if (ser_out !== e) begin
                if (mis[cat] == 0) begin fa[cat] = ser_out; fe[cat] = e; end
                mis[cat]++;
                total++;
            end
        end
        msync = 1'b0; fsync = 1'b0;
        for (int i = 0; i < NCAT; i++) begin
            if (seen[i] > 0) begin
                tests++;
                if (mis[i] != 0) begin
                    fails++;
                    $display("FAIL %s (case %0d, %0d bits) actual %0b expected %0b",
                             CAT_NAME[i], idx, mis[i], fa[i], fe[i]);
                end
            end
        end
        case (idx)
            2:       check("R8 held msync stream mismatches", total == 0, total, 0);
            3:       check("R9 fsync realign stream mismatches", total == 0, total, 0);
            4:       check("R8 second msync edge stream mismatches", total == 0, total, 0);
            default: check("R12 stream mismatches", total == 0, total, 0);
        endcase
    endtask

    initial begin
        for (int i = 0; i < 5; i++) run_scen(i);
        // R1: reset in the middle of a stream clears the output again
        crc_en = 1'b1; ser_in = 1'b1;
        repeat (20) @(negedge clk);
        do_reset();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule